// File: doc/BRIEF.md
# Processor Tick Timer with Period Compare

This block is a core-local tick timer. It holds two software-visible registers of `REG_W` bits: a counter and a control word. The control word packs a compare period, an interrupt-pending flag, an interrupt-enable flag and a 2-bit operating mode. The counter advances by one on each `tick_en` pulse while the timer is running. A match is detected when an increment brings the low `REG_W-4` bits of the counter to the programmed period. What happens next depends on the mode: restart from zero, halt (one-shot), or keep running.

Software reaches both registers through a single-cycle register port. `reg_sel` picks the register, `reg_we` writes it, and `reg_rdata` returns the selected register in the same cycle. The interrupt line is the pending flag gated by the enable flag. It stays asserted until software writes the pending flag back to 0.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset the counter and the control word both read zero and `irq` is low.
- R2: A write with `reg_sel`=0 loads the counter and a write with `reg_sel`=1 loads the control word. `reg_rdata` returns the selected register combinationally. The control word has the period in bits `[REG_W-5:0]`, pending at bit `REG_W-4`, enable at bit `REG_W-3` and mode at bits `[REG_W-1:REG_W-2]`.
- R3: The counter rises by exactly one on a clock edge with `tick_en` high, a nonzero mode, no halt and no counter write. Otherwise it holds, and mode 0 never counts.
- R4: A match fires only on an increment whose result has low `REG_W-4` bits equal to the period. The upper counter bits take no part in the compare. A counter held at the period value, or loaded by software, raises no match.
- R5: In mode 1 a match loads the counter with zero in place of the period value, and counting continues from there. The counter repeats with a length of `period` ticks, or `2^(REG_W-4)` ticks when the period is 0.
- R6: In mode 2 a match leaves the counter at the period value and halts it. A control-word write with a nonzero mode releases the halt.
- R7: In mode 3 the counter passes through the period value and keeps running. It matches again after another `2^(REG_W-4)` ticks.
- R8: A match with the enable bit set sets the pending bit. This set wins over a software write of 0 to the pending bit in the same cycle. With the enable bit clear, a match leaves the pending bit unchanged.
- R9: The pending bit stays set through ticks and counter writes until software writes 0 to it.
- R10: `irq` is high exactly when both the pending bit and the enable bit are set.
- R11: A counter write in the same cycle as an increment or a restart wins. The written value is loaded and no match is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle count pulse |
| reg_sel | input | 1 | Register select: 0 counter, 1 control word |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register |
| irq | output | 1 | Timer interrupt, pending AND enable |

## Verification
The assertions assume that `tick_en`, `reg_we` and `reg_sel` are stable, known single-cycle controls sampled only at rising edges. They also assume that a control-word write and a counter write never happen in the same cycle, which the single-select port ensures. The bench drives every input on the falling edge and holds it for exactly one rising edge. Every simultaneous write-and-tick case therefore arises from deliberate stimulus, never from races. The bench uses an 8-bit configuration (4-bit period), so every period in every mode is swept within a few hundred ticks.

// File: rtl/tick_timer_pkg.sv
// Shared types of the tick timer: the operating-mode encoding.
package tick_timer_pkg;
    typedef enum logic [1:0] {
        TM_OFF     = 2'd0,  // no counting, no action
        TM_RESTART = 2'd1,  // zero the counter on a match
        TM_ONESHOT = 2'd2,  // halt the counter on a match
        TM_FREERUN = 2'd3   // keep counting through a match
    } tmr_mode_e;

    // Control bits above the period field: pending, enable, two mode bits.
    localparam int unsigned CTRL_TOP_BITS = 4;
endpackage

// File: rtl/tmr_ctrl_reg.sv
// Control word of the tick timer: period, pending, enable and mode fields,
// plus the one-shot halt flag.
// Assumes match_hit is a single-cycle event from the counter, and that wr
// is a write strobe already decoded for this register.
module tmr_ctrl_reg
    import tick_timer_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr,
    input  logic [REG_W-1:0]                     wdata,
    input  logic                                 match_hit,
    output logic [REG_W-1:0]                     ctrl_q,
    output logic [REG_W-CTRL_TOP_BITS-1:0]       period,
    output logic                                 ie,
    output logic                                 ip,
    output tmr_mode_e                            mode,
    output logic                                 halted
);
    localparam int unsigned PER_W  = REG_W - CTRL_TOP_BITS;
    localparam int unsigned IP_BIT = PER_W;
    localparam int unsigned IE_BIT = PER_W + 1;

    logic wr_mode_nz;
    logic pend_set;

    assign period     = ctrl_q[PER_W-1:0];
    assign ip         = ctrl_q[IP_BIT];
    assign ie         = ctrl_q[IE_BIT];
    assign mode       = tmr_mode_e'(ctrl_q[REG_W-1 -: 2]);
    assign wr_mode_nz = wr && (wdata[REG_W-1 -: 2] != 2'b00);
    assign pend_set   = match_hit && ie;

    // Purpose: load the control word; a hardware pending-set beats a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q         <= wdata;
            ctrl_q[IP_BIT] <= wdata[IP_BIT] | pend_set;
        end else if (pend_set) begin
            ctrl_q[IP_BIT] <= 1'b1;
        end
    end

    // Purpose: track the one-shot halt, released by a nonzero-mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (wr_mode_nz) begin
            halted <= 1'b0;
        end else if (match_hit && (mode == TM_ONESHOT)) begin
            halted <= 1'b1;
        end
    end

    // R8: an enabled match leaves the pending bit set
    a_r8_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && ie) |=> ip);

    // R8: without a software set or enabled match, pending cannot appear
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!ip && !(match_hit && ie) && !(wr && wdata[IP_BIT])) |=> !ip);

    // R9: pending is sticky while the control word is not written
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ip && !wr) |=> ip);

    // R6: the halt persists until a nonzero-mode write
    a_r6_halt_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !wr_mode_nz) |=> halted);
endmodule

// File: rtl/tmr_counter.sv
// Count register of the tick timer with period compare and mode actions.
// Assumes period, mode and halted come from the control word registers and
// that wr is a write strobe already decoded for the count register.
// A match is raised only by an increment, never by a software load.
module tmr_counter
    import tick_timer_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick_en,
    input  logic                            wr,
    input  logic [REG_W-1:0]                wdata,
    input  logic [REG_W-CTRL_TOP_BITS-1:0]  period,
    input  tmr_mode_e                       mode,
    input  logic                            halted,
    output logic [REG_W-1:0]                cnt_q,
    output logic                            match_hit
);
    localparam int unsigned PER_W = REG_W - CTRL_TOP_BITS;

    logic             running;
    logic             advance;
    logic [REG_W-1:0] cnt_inc;

    // Purpose: decide whether this edge increments and whether it matches.
    always_comb begin
        running   = (mode != TM_OFF) && !halted;
        advance   = tick_en && running && !wr;
        cnt_inc   = cnt_q + {{(REG_W-1){1'b0}}, 1'b1};
        match_hit = advance && (cnt_inc[PER_W-1:0] == period);
    end

    // Purpose: update the count; software load first, then restart, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr) begin
            cnt_q <= wdata;
        end else if (advance) begin
            if (match_hit && (mode == TM_RESTART)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end

    // R11: a software load always lands
    a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt_q == $past(wdata)));

    // R3: a non-matching or non-restart advance steps by one
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !(match_hit && (mode == TM_RESTART)))
            |=> ((cnt_q - $past(cnt_q)) == REG_W'(1)));

    // R3: with no tick, no running state or a load absent, the count holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !(tick_en && running)) |=> $stable(cnt_q));

    // R5: a restart-mode match lands on zero
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && (mode == TM_RESTART)) |=> (cnt_q == '0));

    // R7: a free-running match shows the period in the low bits
    a_r7_pass_period: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && (mode == TM_FREERUN))
            |=> (cnt_q[PER_W-1:0] == $past(period)));
endmodule

// File: rtl/tick_timer.sv
// Top of the tick timer: register-port decode, read mux and interrupt gate.
// Assumes single-cycle register accesses; one register is written per cycle.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    localparam int unsigned PER_W = REG_W - CTRL_TOP_BITS;

    logic             wr_cnt;
    logic             wr_ctrl;
    logic [REG_W-1:0] cnt_q;
    logic [REG_W-1:0] ctrl_q;
    logic [PER_W-1:0] period;
    logic             ie;
    logic             ip;
    logic             halted;
    logic             match_hit;
    tmr_mode_e        mode;

    // Purpose: split the write strobe by register select.
    always_comb begin
        wr_cnt  = reg_we && !reg_sel;
        wr_ctrl = reg_we && reg_sel;
    end

    tmr_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_ctrl),
        .wdata     (reg_wdata),
        .match_hit (match_hit),
        .ctrl_q    (ctrl_q),
        .period    (period),
        .ie        (ie),
        .ip        (ip),
        .mode      (mode),
        .halted    (halted)
    );

    tmr_counter #(.REG_W(REG_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr        (wr_cnt),
        .wdata     (reg_wdata),
        .period    (period),
        .mode      (mode),
        .halted    (halted),
        .cnt_q     (cnt_q),
        .match_hit (match_hit)
    );

    // Purpose: return the selected register and gate the interrupt.
    always_comb begin
        reg_rdata = reg_sel ? ctrl_q : cnt_q;
        irq       = ip && ie;
    end

    // R2: a control-word write lands in the period, enable and mode fields
    a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ((ctrl_q[PER_W-1:0] == $past(reg_wdata[PER_W-1:0]))
                  && (ctrl_q[REG_W-1:PER_W+1] == $past(reg_wdata[REG_W-1:PER_W+1]))));

    // R11: a counter write suppresses the match in its cycle
    a_r11_no_match_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |-> !match_hit);

    // R6: a halted timer never raises a match
    a_r6_halt_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !match_hit);
endmodule

// File: tb/test_tick_timer.sv
// Bench for tick_timer in an 8-bit configuration (4-bit period).
module test_tick_timer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         reg_sel = 1'b0;
    logic         reg_we = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tick_timer #(.REG_W(W)) i_tick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One rising edge with the given controls, then back to idle at the falling edge.
    task automatic step(input logic we, input logic sel, input logic [W-1:0] d, input logic t);
        reg_we = we; reg_sel = sel; reg_wdata = d; tick_en = t;
        @(negedge clk);
        reg_we = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b1);
    endtask

    task automatic rd(input logic sel, output logic [W-1:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    // Compare counter, pending bit (bit 4) and irq.
    task automatic chk_state(input string req, input int cnt, input int ip, input int irq_exp);
        logic [W-1:0] v;
        rd(1'b0, v); chk({req, " count"}, int'(v), cnt);
        rd(1'b1, v); chk({req, " pending"}, int'(v[4]), ip);
        chk({req, " irq"}, int'(irq), irq_exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_state("R1", 0, 0, 0);
        rd(1'b1, v); chk("R1 ctrl", int'(v), 0);

        // R2: register loads and readback
        step(1'b1, 1'b0, 8'hA5, 1'b0);
        rd(1'b0, v); chk("R2 count rd", int'(v), 'hA5);
        step(1'b1, 1'b1, 8'h3F, 1'b0);
        rd(1'b1, v); chk("R2 ctrl rd", int'(v), 'h3F);
        // R10: pending and enable both set
        chk("R10 irq both", int'(irq), 1);
        step(1'b1, 1'b1, 8'h2F, 1'b0);
        chk("R10 irq no pending", int'(irq), 0);
        step(1'b1, 1'b1, 8'h1F, 1'b0);
        chk("R10 irq no enable", int'(irq), 0);

        // R3: mode 0 ignores ticks
        step(1'b1, 1'b1, 8'h20, 1'b0);
        step(1'b1, 1'b0, 8'h03, 1'b0);
        ticks(5);
        chk_state("R3 mode0 hold", 3, 0, 0);

        // R5: restart mode, every period, ie=1
        for (int p = 0; p < 16; p++) begin
            int len;
            len = (p == 0) ? 16 : p;
            step(1'b1, 1'b1, W'(8'h60 | p), 1'b0);
            step(1'b1, 1'b0, 8'h00, 1'b0);
            for (int k = 1; k <= 2 * len + 1; k++) begin
                ticks(1);
                chk_state("R5 restart", k % len, int'(k >= len), int'(k >= len));
            end
        end

        // R6: one-shot, every nonzero period, ie=0
        for (int p = 1; p < 16; p++) begin
            step(1'b1, 1'b1, W'(8'h80 | p), 1'b0);
            step(1'b1, 1'b0, 8'h00, 1'b0);
            for (int k = 1; k <= p + 2; k++) begin
                ticks(1);
                // R8: ie=0 so pending stays clear
                chk_state("R6 oneshot", (k < p) ? k : p, 0, 0);
            end
            step(1'b1, 1'b1, W'(8'h80 | p), 1'b0);
            ticks(1);
            chk_state("R6 release", p + 1, 0, 0);
        end

        // R7: free-running, period 6, ie=1
        step(1'b1, 1'b1, 8'hE6, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        ticks(5);
        chk_state("R7 before match", 5, 0, 0);
        ticks(1);
        chk_state("R7 match", 6, 1, 1);
        repeat (3) step(1'b0, 1'b0, '0, 1'b0);
        chk_state("R3 idle hold", 6, 1, 1);
        step(1'b1, 1'b1, 8'hE6, 1'b0);
        repeat (2) step(1'b0, 1'b0, '0, 1'b0);
        // R4: held at the period value, no second match
        chk_state("R4 held no refire", 6, 0, 0);
        ticks(15);
        chk_state("R7 wrap no match", 'h15, 0, 0);
        ticks(1);
        chk_state("R7 second match", 'h16, 1, 1);

        // R11: counter load beats an increment that would match
        step(1'b1, 1'b1, 8'h64, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        ticks(3);
        chk_state("R11 setup", 3, 0, 0);
        step(1'b1, 1'b0, 8'h20, 1'b1);
        chk_state("R11 load wins", 'h20, 0, 0);
        ticks(3);
        chk_state("R4 upper bits ignored pre", 'h23, 0, 0);
        ticks(1);
        chk_state("R4 upper bits ignored", 0, 1, 1);
        // R9: pending survives ticks and counter loads
        ticks(2);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk_state("R9 sticky", 0, 1, 1);
        step(1'b1, 1'b1, 8'h64, 1'b0);
        chk_state("R9 sw clear", 0, 0, 0);

        // R8: enabled match beats a same-cycle software clear
        step(1'b1, 1'b1, 8'hF2, 1'b0);
        step(1'b1, 1'b0, 8'h01, 1'b0);
        step(1'b1, 1'b1, 8'hE2, 1'b1);
        chk_state("R8 set wins", 2, 1, 1);
        step(1'b1, 1'b1, 8'hE2, 1'b0);
        chk_state("R8 clear alone", 2, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule